// File: doc/BRIEF.md
# Master-Slave JK Flip-Flop Emulator

This block models a two-stage JK storage element one system clock at a time. A slow bit clock `c_i` is treated as an ordinary synchronous input on the fast system clock `clk_i`. While `c_i` is high, the first stage (master) takes in the gated J/K request and the second stage (slave) holds. When a falling edge of `c_i` is seen, the slave takes the master's value, and that value is the visible output. The J and K terms seen by the element are the AND of several input lines each.

Two input disciplines can be chosen. In catching mode, feedback from the slave opens only one of the two master input gates. A brief J pulse while the output is 0, or a brief K pulse while it is 1, is therefore kept even if the pulse ends before the bit clock falls, and the master cannot turn back within one high phase. In lockout mode, J and K are taken only at the cycle where the rising edge of `c_i` is detected, and they are ignored for the rest of the high phase. Asynchronous set and clear lines act on both stages at once and take precedence over clocked operation.

Top module: `msjk_flipflop`

## Requirements
- R1: With set and clear inactive, `q_o` changes only on the system clock edge at which `c_i` is sampled 0 after having been sampled 1 on the previous edge (a falling edge). In particular, `q_o` never changes during a high phase of `c_i`.
- R2: At a falling edge, `q_o` takes the master value. Write Jint and Kint for the internal J and K terms. If the output was 0 the new value is 1 exactly when Jint was caught, and if the output was 1 the new value is 0 exactly when Kint was caught. So Jint=Kint=1 toggles the output, Jint alone gives 1 and Kint alone gives 0.
- R3: Changes of J and K while `c_i` is low have no effect on `q_o` at the following falling edge.
- R4: With `mode_i`=0 (catching), Jint=1 on any system clock edge of the high phase while the output is 0 makes the next value 1. Kint=1 on any such edge while the output is 1 makes it 0. This holds even if the term returns to 0 before the falling edge, and the master does not revert within that phase.
- R5: With `mode_i`=1 (lockout), only J and K sampled on the system clock edge where the rising edge of `c_i` is detected (previous sample 0, current sample 1) decide the next value. Later changes during that high phase are ignored.
- R6: With all J and K lines held at 1, every full cycle of `c_i` inverts `q_o`, in both modes.
- R7: Jint is the AND of all lines of `j_i`, and Kint is the AND of all lines of `k_i`. A pattern with any line at 0 acts as an inactive term.
- R8: `set_i`=1 forces `q_o` to 1, and `clr_i`=1 forces it to 0, in the same cycle without waiting for a clock edge. Both stages are forced, so after release with J=K=0 the forced value survives the next full `c_i` cycle, even when the override coincided with a falling edge of `c_i`.
- R9: With `set_i` and `clr_i` both 1, `q_o` is 0. `qn_o` is always the complement of `q_o`.
- R10: While `rst_n_i` is 0, both stages are 0, so `q_o`=0 and `qn_o`=1.
- R11: With Jint=Kint=0 throughout a high phase, `q_o` keeps its value across the `c_i` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, rising edge |
| rst_n_i | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| c_i | input | 1 | Bit clock, sampled on `clk_i` |
| j_i | input | N_J | J lines, ANDed internally |
| k_i | input | N_K | K lines, ANDed internally |
| set_i | input | 1 | Asynchronous set of both stages, active high |
| clr_i | input | 1 | Asynchronous clear of both stages, active high, wins over set |
| mode_i | input | 1 | 0 = catching, 1 = lockout |
| q_o | output | 1 | Slave output |
| qn_o | output | 1 | Complement of `q_o` |

## Verification
The override and the slave transfer can fall in the same system cycle. To provoke this, the master is loaded with 1 while the output is 0, and then clear is raised in the same cycle that the bit clock falls. The output must read 0 at once and remain 0 through the following quiet bit-clock cycle, which shows that the master was cleared too and that the transfer did not win. A second case raises set in the middle of a catching high phase with K held. The output must go to 1 at once, and the feedback must then let the held K clear the master before the fall.

// File: rtl/msjk_pkg.sv
package msjk_pkg;

  typedef enum logic {
    MODE_CATCH   = 1'b0,
    MODE_LOCKOUT = 1'b1
  } msjk_mode_e;

  typedef struct packed {
    logic set_req;
    logic clr_req;
  } msjk_req_t;

endpackage

// File: rtl/msjk_rst_sync.sv
module msjk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_sync_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_nxt;
    end
  end

  assign rst_sync_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/msjk_edge_detect.sv
module msjk_edge_detect (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic c_i,
  output logic c_prev_o,
  output logic c_rise_o,
  output logic c_fall_o
);

  logic prev_q;
  logic prev_nxt;

  always_comb begin
    prev_nxt = c_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_nxt;
    end
  end

  assign c_prev_o = prev_q;
  assign c_rise_o = c_i & ~prev_q;
  assign c_fall_o = ~c_i & prev_q;

endmodule

// File: rtl/msjk_input_gate.sv
module msjk_input_gate
  import msjk_pkg::*;
#(
  parameter int N_J = 2,
  parameter int N_K = 2
) (
  input  logic [N_J-1:0] j_i,
  input  logic [N_K-1:0] k_i,
  input  logic           q_fb_i,
  output msjk_req_t      req_o
);

  logic j_int;
  logic k_int;

  generate
    if (N_J == 1) begin : g_j_single
      assign j_int = j_i[0];
    end else begin : g_j_and
      assign j_int = &j_i;
    end
    if (N_K == 1) begin : g_k_single
      assign k_int = k_i[0];
    end else begin : g_k_and
      assign k_int = &k_i;
    end
  endgenerate

  // Feedback from the slave opens only one gate at a time.
  always_comb begin
    req_o.set_req = j_int & ~q_fb_i;
    req_o.clr_req = k_int &  q_fb_i;
  end

endmodule

// File: rtl/msjk_master.sv
module msjk_master
  import msjk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  msjk_mode_e mode_i,
  input  logic       c_high_i,
  input  logic       c_rise_i,
  input  msjk_req_t  req_i,
  input  logic       force_set_i,
  input  logic       force_clr_i,
  output logic       master_o
);

  logic m_q;
  logic m_nxt;
  logic gate_en;
  logic m_en;

  always_comb begin
    gate_en = (mode_i == MODE_LOCKOUT) ? c_rise_i : c_high_i;
    m_en    = force_set_i | force_clr_i | gate_en;
    if (force_clr_i) begin
      m_nxt = 1'b0;
    end else if (force_set_i) begin
      m_nxt = 1'b1;
    end else if (req_i.set_req) begin
      m_nxt = 1'b1;
    end else if (req_i.clr_req) begin
      m_nxt = 1'b0;
    end else begin
      m_nxt = m_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      m_q <= 1'b0;
    end else if (m_en) begin
      m_q <= m_nxt;
    end
  end

  assign master_o = m_q;

endmodule

// File: rtl/msjk_flipflop.sv
module msjk_flipflop
  import msjk_pkg::*;
#(
  parameter int N_J = 2,
  parameter int N_K = 2
) (
  input  logic           clk_i,
  input  logic           rst_n_i,
  input  logic           c_i,
  input  logic [N_J-1:0] j_i,
  input  logic [N_K-1:0] k_i,
  input  logic           set_i,
  input  logic           clr_i,
  input  logic           mode_i,
  output logic           q_o,
  output logic           qn_o
);

  logic       rst_sync_n;
  logic       c_prev;
  logic       c_rise;
  logic       c_fall;
  logic       master_q;
  logic       slave_q;
  logic       slave_nxt;
  logic       slave_en;
  msjk_req_t  req;
  msjk_mode_e mode;

  assign mode = msjk_mode_e'(mode_i);

  msjk_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n_i),
    .rst_sync_n_o (rst_sync_n)
  );

  msjk_edge_detect i_edge (
    .clk_i    (clk_i),
    .rst_n_i  (rst_sync_n),
    .c_i      (c_i),
    .c_prev_o (c_prev),
    .c_rise_o (c_rise),
    .c_fall_o (c_fall)
  );

  msjk_input_gate #(.N_J(N_J), .N_K(N_K)) i_gate (
    .j_i    (j_i),
    .k_i    (k_i),
    .q_fb_i (slave_q),
    .req_o  (req)
  );

  msjk_master i_master (
    .clk_i       (clk_i),
    .rst_n_i     (rst_sync_n),
    .mode_i      (mode),
    .c_high_i    (c_i),
    .c_rise_i    (c_rise),
    .req_i       (req),
    .force_set_i (set_i),
    .force_clr_i (clr_i),
    .master_o    (master_q)
  );

  // Slave stage: copies the master on a falling edge of the bit clock.
  always_comb begin
    slave_en = set_i | clr_i | c_fall;
    if (clr_i) begin
      slave_nxt = 1'b0;
    end else if (set_i) begin
      slave_nxt = 1'b1;
    end else begin
      slave_nxt = master_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      slave_q <= 1'b0;
    end else if (slave_en) begin
      slave_q <= slave_nxt;
    end
  end

  // Overrides reach the output without waiting for a clock edge.
  always_comb begin
    if (clr_i) begin
      q_o = 1'b0;
    end else if (set_i) begin
      q_o = 1'b1;
    end else begin
      q_o = slave_q;
    end
    qn_o = ~q_o;
  end

endmodule

// File: rtl/msjk_checker.sv
module msjk_checker (
  input logic clk_i,
  input logic rst_n_i,
  input logic c_i,
  input logic c_prev_i,
  input logic mode_i,
  input logic set_i,
  input logic clr_i,
  input logic master_i,
  input logic slave_i,
  input logic q_i,
  input logic qn_i
);

  // R1: without a falling edge or override the slave keeps its value
  a_r1_slave_holds: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!(c_prev_i && !c_i) && !set_i && !clr_i) |=> $stable(slave_i));

  // R4: in catching mode a caught 1 is not lost within the high phase
  a_r4_no_revert_up: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!mode_i && c_i && !set_i && !clr_i && !slave_i && master_i) |=> master_i);

  // R4: in catching mode a caught 0 is not lost within the high phase
  a_r4_no_revert_down: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!mode_i && c_i && !set_i && !clr_i && slave_i && !master_i) |=> !master_i);

  // R5: in lockout mode the master is frozen after the rising-edge cycle
  a_r5_lockout_frozen: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (mode_i && c_i && c_prev_i && !set_i && !clr_i) |=> $stable(master_i));

  // R9: clear wins
  a_r9_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    clr_i |-> !q_i);

  // R9: outputs are complementary
  a_r9_outputs_differ: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (q_i ^ qn_i));

  // R8: set alone forces the output high
  a_r8_set_forces: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (set_i && !clr_i) |-> q_i);

endmodule

bind msjk_flipflop msjk_checker i_msjk_checker (
  .clk_i    (clk_i),
  .rst_n_i  (rst_sync_n),
  .c_i      (c_i),
  .c_prev_i (c_prev),
  .mode_i   (mode_i),
  .set_i    (set_i),
  .clr_i    (clr_i),
  .master_i (master_q),
  .slave_i  (slave_q),
  .q_i      (q_o),
  .qn_i     (qn_o)
);

// File: tb/test_msjk_flipflop.sv
module test_msjk_flipflop;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 2;

  logic          clk;
  logic          rst_n;
  logic          c;
  logic [NL-1:0] j;
  logic [NL-1:0] k;
  logic          set_in;
  logic          clr_in;
  logic          mode;
  logic          q;
  logic          qn;

  int  n_checks;
  int  n_fail;
  bit  done;
  logic mq;

  msjk_flipflop #(.N_J(NL), .N_K(NL)) i_msjk_flipflop (
    .clk_i   (clk),
    .rst_n_i (rst_n),
    .c_i     (c),
    .j_i     (j),
    .k_i     (k),
    .set_i   (set_in),
    .clr_i   (clr_in),
    .mode_i  (mode),
    .q_o     (q),
    .qn_o    (qn)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp || qn !== ~act) begin
      n_fail++;
      $display("FAIL %s: q=%b qn=%b expected q=%b qn=%b", tag, act, qn, exp, ~exp);
    end
  endtask

  function automatic logic ref_next(input logic md, input logic qo,
                                    input logic [NL-1:0] j1, input logic [NL-1:0] k1,
                                    input logic [NL-1:0] j2, input logic [NL-1:0] k2);
    logic ja, ka;
    if (md) begin
      ja = &j1; ka = &k1;
    end else begin
      ja = (&j1) | (&j2); ka = (&k1) | (&k2);
    end
    return qo ? ~ka : ja;
  endfunction

  // one full bit-clock cycle: j1/k1 from the rise, j2/k2 in the later high phase
  task automatic bit_cycle(input logic [NL-1:0] j1, input logic [NL-1:0] k1,
                           input logic [NL-1:0] j2, input logic [NL-1:0] k2,
                           input string tag);
    logic exp;
    exp = ref_next(mode, mq, j1, k1, j2, k2);
    @(negedge clk);
    c = 1'b1; j = j1; k = k1;
    repeat (3) @(negedge clk);
    check("R1", q, mq);
    j = j2; k = k2;
    repeat (3) @(negedge clk);
    check("R1", q, mq);
    c = 1'b0; j = '1; k = '1;   // R3: low-phase activity must be ignored
    repeat (2) @(negedge clk);
    check(tag, q, exp);
    mq = exp;
    j = '0; k = '0;
  endtask

  task automatic force_to(input logic val);
    @(negedge clk);
    if (val) set_in = 1'b1; else clr_in = 1'b1;
    #1;
    check("R8", q, val);
    repeat (2) @(negedge clk);
    set_in = 1'b0; clr_in = 1'b0;
    #1;
    check("R8", q, val);
    mq = val;
  endtask

  function automatic string pick_tag(input logic md, input logic [NL-1:0] j1,
                                     input logic [NL-1:0] k1, input logic [NL-1:0] j2,
                                     input logic [NL-1:0] k2);
    if (j1 == '1 && k1 == '1 && j2 == '1 && k2 == '1) return "R6";
    if (j1 != j2 || k1 != k2) return md ? "R5" : "R4";
    if (!(&j1) && !(&k1)) return (j1 == '0 && k1 == '0) ? "R11" : "R7";
    return "R2";
  endfunction

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; c = 1'b0; j = '0; k = '0;
    set_in = 1'b0; clr_in = 1'b0; mode = 1'b0; mq = 1'b0;
    repeat (3) @(negedge clk);
    check("R10", q, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", q, 1'b0);

    // R9: both overrides asserted
    set_in = 1'b1; clr_in = 1'b1;
    #1;
    check("R9", q, 1'b0);
    @(negedge clk);
    set_in = 1'b0; clr_in = 1'b0;

    // exhaustive sweep of two-phase J/K patterns, both modes, both start states
    for (int md = 0; md < 2; md++) begin
      @(negedge clk);
      mode = md[0];
      for (int init = 0; init < 2; init++) begin
        for (int v = 0; v < 256; v++) begin
          logic [7:0] vv;
          vv = 8'(v);
          force_to(init[0]);
          bit_cycle(vv[1:0], vv[3:2], vv[5:4], vv[7:6],
                    pick_tag(md[0], vv[1:0], vv[3:2], vv[5:4], vv[7:6]));
        end
      end
    end

    // R6: toggle run in each mode
    for (int md = 0; md < 2; md++) begin
      @(negedge clk);
      mode = md[0];
      force_to(1'b0);
      for (int n = 0; n < 4; n++) begin
        bit_cycle('1, '1, '1, '1, "R6");
        check("R6", q, ~n[0]);
      end
    end

    // R8: clear in the same cycle as the falling edge, master holding 1
    @(negedge clk);
    mode = 1'b0;
    force_to(1'b0);
    @(negedge clk);
    c = 1'b1; j = '1; k = '0;
    repeat (2) @(negedge clk);
    j = '0;
    repeat (2) @(negedge clk);
    c = 1'b0; clr_in = 1'b1;
    #1;
    check("R8", q, 1'b0);
    @(negedge clk);
    check("R8", q, 1'b0);
    clr_in = 1'b0;
    #1;
    check("R8", q, 1'b0);
    mq = 1'b0;
    bit_cycle('0, '0, '0, '0, "R8");

    // R8/R4: set mid high phase with K held, feedback then lets K clear
    @(negedge clk);
    c = 1'b1; j = '0; k = '1;
    repeat (2) @(negedge clk);
    set_in = 1'b1;
    #1;
    check("R8", q, 1'b1);
    repeat (2) @(negedge clk);
    set_in = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", q, 1'b1);
    c = 1'b0; k = '0;
    repeat (2) @(negedge clk);
    check("R4", q, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule